// File: doc/BRIEF.md
# Video Stream One-Line Delay Buffer

This block sits in a video stream as a pass-through stage with a stream slave input and a stream master output for 24-bit pixels. Every accepted input beat is packed into one 32-bit word, holding the pixel, the 3-bit byte-strobe and byte-keep fields, the end-of-line flag and the start-of-frame flag. That word goes into a first-word-fall-through FIFO, and the master side is driven directly from the FIFO head.

After reset the output stays silent until one whole line is stored. A line is complete when a beat carrying the end-of-line flag is accepted. From then on the output runs freely. The extra line of latency is paid once at the start of streaming, and the output pixel rate then follows the input. No blanking or idle beats are added.

The input ready signal is withdrawn whenever the FIFO has no room. A stalled sink therefore pushes backpressure to the source, and no word is lost or overwritten. The FIFO depth must hold at least one maximum-length line. Otherwise the priming wait could never end.

Top module: `vid_line_delay`

## Requirements
- R1: After reset is released, `m_tvalid` is 0 and `s_tready` is 1, because the FIFO is empty.
- R2: `m_tvalid` stays 0 from reset until a beat with `s_tlast`=1 has been accepted. It may go high from the cycle after that acceptance onward.
- R3: `s_tready` is 1 exactly when the FIFO holds fewer than `DEPTH` words, so the FIFO is never written while full.
- R4: Every accepted beat appears at the output exactly once, in order. Its `tdata`, `tstrb`, `tkeep`, `tlast` and `tuser` (start of frame, bit 0) values are unchanged.
- R5: While `m_tvalid`=1 and `m_tready`=0, on the next cycle `m_tvalid` is still 1 and all output payload fields are unchanged.
- R6: Once primed, the block stays primed until reset. `m_tvalid` is 1 whenever the FIFO is non-empty, including for a partial line that has no end-of-line beat.
- R7: A reset in the middle of a stream discards the stored words and re-arms the priming wait. A new full line is needed before output resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_tdata | input | 24 | Input pixel |
| s_tstrb | input | 3 | Input byte strobe, carried through |
| s_tkeep | input | 3 | Input byte keep, carried through |
| s_tlast | input | 1 | Input end of line |
| s_tuser | input | 1 | Input start of frame |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input may be accepted (FIFO not full) |
| m_tdata | output | 24 | Output pixel |
| m_tstrb | output | 3 | Output byte strobe |
| m_tkeep | output | 3 | Output byte keep |
| m_tlast | output | 1 | Output end of line |
| m_tuser | output | 1 | Output start of frame |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream accepts beat |

## Verification
The bench holds the sink off long enough for the FIFO to fill completely. A design that writes while full would overwrite a word, and the scoreboard would see a missing or repeated pixel. The first line is checked beat by beat against the priming rule: a design that releases output too early, or that waits for every line, would show `m_tvalid` in the wrong cycles. A trailing partial line checks that priming is sticky. A reset in the middle of a line checks that stale words are discarded and that the priming wait is armed again. The sink stalls at random throughout, so the output must hold its beat steady whenever it is refused.

// File: rtl/vld_pkg.sv
// Package: shared widths and the packed FIFO word for the line-delay buffer.
// Assumes one pixel per beat. The field order is fixed because the FIFO word
// layout is relied on: user[31], last[30], keep[29:27], strb[26:24], data[23:0].
package vld_pkg;
    localparam int PIX_W  = 24;
    localparam int SIDE_W = PIX_W / 8;

    typedef struct packed {
        logic              sof;
        logic              eol;
        logic [SIDE_W-1:0] keep;
        logic [SIDE_W-1:0] strb;
        logic [PIX_W-1:0]  pix;
    } beat_t;

    localparam int WORD_W = $bits(beat_t);
endpackage

// File: rtl/vld_fifo.sv
// Module: vld_fifo
// First-word-fall-through FIFO. The head word appears at rd_data whenever
// empty is low. Assumes the caller never writes while full and never reads
// while empty. The assertions guard both. Synchronous active-low reset.
module vld_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full,
    output logic [CW-1:0]    level
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;

    // Pointer step with wrap at DEPTH-1, so any depth works.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write; no reset is needed on the data array.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    // Pointers and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) rd_ptr <= bump(rd_ptr);
            if (wr_en && !rd_en)      level <= level + 1'b1;
            else if (!wr_en && rd_en) level <= level - 1'b1;
        end
    end

    assign rd_data = mem[rd_ptr];
    assign empty   = (level == '0);
    assign full    = (level == CW'(DEPTH));

    // R3: a write never arrives while the FIFO is full.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (level < CW'(DEPTH)));
    // R4: a read never arrives while empty, so no word is duplicated.
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (level != '0));
    // R3: the occupancy count never exceeds the depth.
    assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));
endmodule

// File: rtl/vld_prime.sv
// Module: vld_prime
// Priming flag. It is set when the first end-of-line beat is accepted after
// reset and then holds until the next reset. Synchronous active-low reset.
module vld_prime (
    input  logic clk,
    input  logic rst_n,
    input  logic line_done,
    output logic primed
);
    // Sticky flag: once set it is cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         primed <= 1'b0;
        else if (line_done) primed <= 1'b1;
    end

    // R6: priming is never withdrawn outside reset.
    assert_prime_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        primed |=> primed);
endmodule

// File: rtl/vid_line_delay.sv
// Module: vid_line_delay (top)
// Video stream pass-through that holds the output until one full line is
// buffered. Assumes DEPTH >= MAX_LINE beats, a single clock and one pixel per
// beat. Input backpressure comes straight from the FIFO full flag.
module vid_line_delay #(
    parameter int MAX_LINE = 16,
    parameter int DEPTH    = 32,
    localparam int PW      = vld_pkg::PIX_W,
    localparam int SW      = vld_pkg::SIDE_W,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] s_tdata,
    input  logic [SW-1:0] s_tstrb,
    input  logic [SW-1:0] s_tkeep,
    input  logic          s_tlast,
    input  logic          s_tuser,
    input  logic          s_tvalid,
    output logic          s_tready,
    output logic [PW-1:0] m_tdata,
    output logic [SW-1:0] m_tstrb,
    output logic [SW-1:0] m_tkeep,
    output logic          m_tlast,
    output logic          m_tuser,
    output logic          m_tvalid,
    input  logic          m_tready
);
    import vld_pkg::*;

    if (DEPTH < MAX_LINE) begin : g_depth_check
        $error("vid_line_delay: DEPTH must hold at least one line");
    end

    beat_t         in_word;
    beat_t         out_word;
    logic          fifo_empty;
    logic          fifo_full;
    logic [CW-1:0] fifo_level;
    logic          wr_en;
    logic          rd_en;
    logic          primed;

    // Pack the incoming beat and its sideband into one FIFO word.
    always_comb begin
        in_word.sof  = s_tuser;
        in_word.eol  = s_tlast;
        in_word.keep = s_tkeep;
        in_word.strb = s_tstrb;
        in_word.pix  = s_tdata;
    end

    assign s_tready = !fifo_full;
    assign wr_en    = s_tvalid && s_tready;
    assign m_tvalid = primed && !fifo_empty;
    assign rd_en    = m_tvalid && m_tready;

    vld_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (in_word),
        .rd_en   (rd_en),
        .rd_data (out_word),
        .empty   (fifo_empty),
        .full    (fifo_full),
        .level   (fifo_level)
    );

    vld_prime prime_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_done (wr_en && s_tlast),
        .primed    (primed)
    );

    // Unpack the FIFO head word onto the master side.
    always_comb begin
        m_tdata = out_word.pix;
        m_tstrb = out_word.strb;
        m_tkeep = out_word.keep;
        m_tlast = out_word.eol;
        m_tuser = out_word.sof;
    end

    // R5: a refused beat stays offered with the same payload.
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tstrb)
            && $stable(m_tkeep) && $stable(m_tlast) && $stable(m_tuser)));
    // R2: priming takes effect only with the finished line already stored.
    assert_prime_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(primed) |-> (fifo_level != '0));
endmodule

// File: tb/vid_line_delay_tb_top.sv
// Scoreboard bench. Driver tasks push accepted beats into a queue, and a
// monitor on the falling edge pops and compares every accepted output beat.
module vid_line_delay_tb_top;
    localparam int MAX_LINE = 16;
    localparam int DEPTH    = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] s_tdata = '0;
    logic [2:0]  s_tstrb = '0;
    logic [2:0]  s_tkeep = '0;
    logic        s_tlast = 1'b0;
    logic        s_tuser = 1'b0;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic [23:0] m_tdata;
    logic [2:0]  m_tstrb;
    logic [2:0]  m_tkeep;
    logic        m_tlast;
    logic        m_tuser;
    logic        m_tvalid;
    logic        m_tready = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int sink_mode = 0;       // 0 off, 1 random, 2 always ready
    logic [31:0] exp_q[$];
    int occ = 0;
    bit prime_m = 0;
    bit prev_stall = 0;
    logic [31:0] prev_word;

    always #4 clk = ~clk;    // 125 MHz

    vid_line_delay #(.MAX_LINE(MAX_LINE), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .s_tdata(s_tdata), .s_tstrb(s_tstrb), .s_tkeep(s_tkeep),
        .s_tlast(s_tlast), .s_tuser(s_tuser), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tstrb(m_tstrb), .m_tkeep(m_tkeep),
        .m_tlast(m_tlast), .m_tuser(m_tuser), .m_tvalid(m_tvalid), .m_tready(m_tready)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] out_word();
        return {m_tuser, m_tlast, m_tkeep, m_tstrb, m_tdata};
    endfunction

    // Sink: drive m_tready just after each rising edge.
    always @(posedge clk) begin
        #1;
        case (sink_mode)
            1:       m_tready = $urandom_range(0, 1);
            2:       m_tready = 1'b1;
            default: m_tready = 1'b0;
        endcase
    end

    // Monitor and scoreboard: evaluate the upcoming edge's handshakes.
    always @(negedge clk) begin
        if (!rst_n) begin
            exp_q.delete();
            occ = 0;
            prime_m = 0;
            prev_stall = 0;
        end else begin
            check(s_tready == (occ < DEPTH), "R3", "s_tready vs occupancy", 32'(s_tready), 32'(occ < DEPTH));
            check(m_tvalid == (prime_m && occ > 0), "R2/R6", "m_tvalid vs priming", 32'(m_tvalid),
                  32'(prime_m && occ > 0));
            if (prev_stall)
                check(m_tvalid && out_word() == prev_word, "R5", "held beat", out_word(), prev_word);
            prev_stall = m_tvalid && !m_tready;
            prev_word  = out_word();
            if (m_tvalid && m_tready) begin
                if (exp_q.size() == 0)
                    check(1'b0, "R4", "unexpected output beat", out_word(), 32'hx);
                else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    check(out_word() == e, "R4", "output beat", out_word(), e);
                end
                occ--;
            end
            if (s_tvalid && s_tready) begin
                exp_q.push_back({s_tuser, s_tlast, s_tkeep, s_tstrb, s_tdata});
                occ++;
                if (s_tlast) prime_m = 1;
            end
        end
    end

    task automatic send_beat(input bit last, input bit sof, input int gap);
        repeat (gap) begin @(posedge clk); #1; s_tvalid = 1'b0; end
        s_tdata  = $urandom;
        s_tstrb  = $urandom;
        s_tkeep  = $urandom;
        s_tlast  = last;
        s_tuser  = sof;
        s_tvalid = 1'b1;
        do @(negedge clk); while (!s_tready);
        @(posedge clk); #1;
        s_tvalid = 1'b0;
    endtask

    task automatic send_line(input int len, input bit sof, input bit rnd);
        for (int i = 0; i < len; i++)
            send_beat(i == len - 1, sof && i == 0, rnd ? $urandom_range(0, 2) : 0);
    endtask

    task automatic do_reset();
        sink_mode = 0;
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(m_tvalid == 1'b0, "R1", "m_tvalid after reset", 32'(m_tvalid), 0);
        check(s_tready == 1'b1, "R1", "s_tready after reset", 32'(s_tready), 1);
    endtask

    task automatic drain();
        sink_mode = 2;
        for (int i = 0; i < 400 && occ > 0; i++) @(negedge clk);
        check(occ == 0 && exp_q.size() == 0, "R4", "all beats delivered", 32'(exp_q.size()), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset();                                    // R1
        // R2: first line with the sink ready; no output before its end.
        sink_mode = 2;
        send_line(MAX_LINE, 1'b1, 1'b0);
        // R4, R5: more lines with random gaps and random sink stalls.
        sink_mode = 1;
        for (int l = 0; l < 5; l++) send_line(8, 1'b0, 1'b1);
        drain();
        // R3: sink held off until the FIFO fills, then released.
        sink_mode = 0;
        fork
            for (int l = 0; l < 6; l++) send_line(8, l == 0, 1'b0);
            begin
                repeat (60) @(negedge clk);
                check(s_tready == 1'b0, "R3", "backpressure when full", 32'(s_tready), 0);
                check(occ == DEPTH, "R3", "occupancy at full", 32'(occ), DEPTH);
                sink_mode = 1;
            end
        join
        drain();
        // R6: a partial line after priming is forwarded without waiting.
        send_beat(1'b0, 1'b0, 0);
        send_beat(1'b0, 1'b0, 0);
        repeat (3) @(negedge clk);
        check(occ == 0, "R6", "partial line forwarded", 32'(occ), 0);
        // R7: reset in the middle of a line re-arms priming.
        sink_mode = 0;
        for (int i = 0; i < 5; i++) send_beat(1'b0, i == 0, 0);
        do_reset();
        for (int i = 0; i < 4; i++) send_beat(1'b0, i == 0, 0);
        sink_mode = 2;
        repeat (5) @(negedge clk);
        check(m_tvalid == 1'b0, "R7", "no output before new line ends", 32'(m_tvalid), 0);
        send_beat(1'b1, 1'b0, 0);
        drain();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule